// File: doc/BRIEF.md
# Debounced Edge Event Counter

The block counts edges of one chosen polarity on a slow, already synchronized input, such as a mechanical switch contact, into a wrapping event register. When it counts an edge, the detector disarms. It stays disarmed for a programmable number of debounce time units. While it is disarmed, every further edge on the input is discarded, so contact bounce on both the closing and the opening of a switch adds nothing to the total.

A free-running unit tick, made outside the block, measures the lockout. The tick is not aligned to the counted edge. The first tick after the edge therefore closes a partial unit. The block re-arms after that first tick and N further ticks, where N is the programmed debounce count. The real lockout is thus N units plus a fraction of one more.

Software drives the block through two write strobes that share one data bus. A configuration write loads the debounce count and the polarity. A plain update write of zero clears the event register. The register output is a flop, so a read in the cycle of a clear still returns the old total.

Top module: `edge_tally_debounced`

## Requirements
- R1: After reset the count is 0, the detector is armed, the debounce count is 0 and falling edges are selected.
- R2: With the polarity bit wr_data[8] written as 0, a 1-to-0 transition of pin_sync raises the count by one in the clock cycle where the transition is seen, and 0-to-1 transitions are not counted.
- R3: With the polarity bit wr_data[8] written as 1, 0-to-1 transitions are counted and 1-to-0 transitions are not.
- R4: After a counted edge, all edges are ignored until the unit tick has been seen N+1 times, where N is the debounce count from wr_data[7:0]. The detector re-arms in the cycle after that tick, and an edge seen there is counted.
- R5: With N = 0, the first unit tick after a counted edge re-arms the detector.
- R6: A unit tick in the same cycle as a counted edge does not count toward that edge's lockout.
- R7: An update write (upd_wr high, cfg_wr low) with wr_data equal to 0 clears the count on the next clock edge, and the count still shows the old value during the write cycle. An update write with nonzero data has no effect.
- R8: A configuration write loads the debounce count and polarity and leaves the count unchanged, even when upd_wr is raised in the same cycle with zero data.
- R9: When a clear and a counted edge fall in the same cycle, the count becomes 0 and the lockout for that edge still begins.
- R10: The count wraps from its all-ones value to 0.
- R11: No edge is counted in the first clock cycle after reset, whatever the level of pin_sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_tick | input | 1 | One-cycle pulse marking each debounce time unit |
| pin_sync | input | 1 | Synchronized external input level |
| cfg_wr | input | 1 | Configuration write strobe |
| upd_wr | input | 1 | Update write strobe (zero data clears the count) |
| wr_data | input | DATA_W | Write data: [7:0] debounce count, [8] polarity |
| count | output | CNT_W | Edge event register |

## Verification
A lockout flag stuck or released early shows at the count port on the very next edge of the selected polarity. The total is then one too low or one too high, and it stays off from that point on. A lockout counter that is off by one is visible only when an edge falls in the cycle right after the N+1-th tick, so the vectors place edges just before and just after that boundary. A polarity or edge-history error shows within one cycle of the first transition after configuration or reset.

// File: rtl/edge_tally_debounced.sv
module edge_tally_debounced #(
  parameter int CNT_W  = 32,
  parameter int UNIT_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_tick,
  input  logic              pin_sync,
  input  logic              cfg_wr,
  input  logic              upd_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count
);
  localparam int POL_BIT = 8;

  logic [UNIT_W-1:0] hold;
  logic [UNIT_W-1:0] lock_cnt;
  logic              rise_sel;
  logic              prev_lvl;
  logic              primed;
  logic              locked;

  wire edge_seen   = primed && (rise_sel ? (pin_sync && !prev_lvl) : (!pin_sync && prev_lvl));
  wire take        = edge_seen && !locked;
  wire clear       = upd_wr && !cfg_wr && (wr_data == '0);
  wire release_now = locked && unit_tick && (lock_cnt >= hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      rise_sel <= 1'b0;
      prev_lvl <= 1'b1;
      primed   <= 1'b0;
      locked   <= 1'b0;
      lock_cnt <= '0;
      count    <= '0;
    end else begin
      prev_lvl <= pin_sync;
      primed   <= 1'b1;
      if (cfg_wr) begin
        hold     <= wr_data[UNIT_W-1:0];
        rise_sel <= wr_data[POL_BIT];
      end
      if (clear)     count <= '0;
      else if (take) count <= count + 1'b1;
      if (take) begin
        locked   <= 1'b1;
        lock_cnt <= '0;
      end else if (release_now) begin
        locked   <= 1'b0;
      end else if (locked && unit_tick) begin
        lock_cnt <= lock_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_tally_debounced_chk.sv
module edge_tally_debounced_chk #(
  parameter int CNT_W  = 32,
  parameter int UNIT_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unit_tick,
  input logic              cfg_wr,
  input logic              upd_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic              locked,
  input logic [UNIT_W-1:0] lock_cnt,
  input logic [UNIT_W-1:0] hold
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0 || count == CNT_W'($past(count) + 1'b1)));
  // R4
  no_count_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> (count == $past(count) || count == '0));
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_wr && !cfg_wr && wr_data == '0) |=> (count == '0));
  // R6
  lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (lock_cnt == '0));
  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && unit_tick && lock_cnt >= hold) |=> (!locked || lock_cnt == '0));
endmodule

bind edge_tally_debounced edge_tally_debounced_chk #(
  .CNT_W(CNT_W), .UNIT_W(UNIT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .cfg_wr(cfg_wr),
  .upd_wr(upd_wr), .wr_data(wr_data), .count(count), .locked(locked),
  .lock_cnt(lock_cnt), .hold(hold)
);

// File: tb/test_edge_tally_debounced.sv
module test_edge_tally_debounced;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 39;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unit_tick = 1'b0;
  logic        pin_sync = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        upd_wr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] count;
  logic [3:0]  count_small;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_tally_debounced i_edge_tally_debounced (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .pin_sync(pin_sync),
    .cfg_wr(cfg_wr), .upd_wr(upd_wr), .wr_data(wr_data), .count(count));

  edge_tally_debounced #(.CNT_W(4)) i_small (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .pin_sync(pin_sync),
    .cfg_wr(cfg_wr), .upd_wr(upd_wr), .wr_data(wr_data), .count(count_small));

  // {req, pin, tick, cfg, upd, data, expected count after the edge}
  localparam logic [59:0] VECS [NV] = '{
    {8'd8,  1'b1,1'b0,1'b1,1'b0,16'h0002,32'd0}, // R8 falling, N=2
    {8'd2,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd0},
    {8'd2,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd1}, // R2 counted
    {8'd2,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd1}, // R2 rise ignored
    {8'd4,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd1}, // R4 in lockout
    {8'd4,  1'b0,1'b1,1'b0,1'b0,16'h0000,32'd1},
    {8'd4,  1'b1,1'b1,1'b0,1'b0,16'h0000,32'd1},
    {8'd4,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd1}, // R4 still locked
    {8'd4,  1'b1,1'b1,1'b0,1'b0,16'h0000,32'd1}, // third tick releases
    {8'd4,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd2}, // R4 counted after release
    {8'd7,  1'b0,1'b0,1'b0,1'b1,16'h0005,32'd2}, // R7 nonzero ignored
    {8'd7,  1'b0,1'b0,1'b0,1'b1,16'h0000,32'd0}, // R7 clear
    {8'd4,  1'b0,1'b1,1'b0,1'b0,16'h0000,32'd0},
    {8'd4,  1'b0,1'b1,1'b0,1'b0,16'h0000,32'd0},
    {8'd4,  1'b1,1'b1,1'b0,1'b0,16'h0000,32'd0},
    {8'd4,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd1},
    {8'd8,  1'b0,1'b0,1'b1,1'b0,16'h0100,32'd1}, // R8 rising, N=0
    {8'd5,  1'b0,1'b1,1'b0,1'b0,16'h0000,32'd1}, // R5 one tick releases
    {8'd3,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd2}, // R3 rise counted
    {8'd3,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd2},
    {8'd5,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd2}, // R5 locked until tick
    {8'd5,  1'b1,1'b1,1'b0,1'b0,16'h0000,32'd2},
    {8'd3,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd2}, // R3 fall ignored
    {8'd6,  1'b1,1'b1,1'b0,1'b0,16'h0000,32'd3}, // R6 edge with tick
    {8'd6,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd3},
    {8'd6,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd3}, // R6 tick did not count
    {8'd6,  1'b1,1'b1,1'b0,1'b0,16'h0000,32'd3},
    {8'd6,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd3},
    {8'd8,  1'b0,1'b0,1'b1,1'b1,16'h0000,32'd3}, // R8 cfg beats clear
    {8'd8,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd3},
    {8'd8,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd4}, // R8 falling now
    {8'd9,  1'b0,1'b1,1'b0,1'b0,16'h0000,32'd4},
    {8'd9,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd4},
    {8'd9,  1'b0,1'b0,1'b0,1'b1,16'h0000,32'd0}, // R9 clear wins
    {8'd9,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd0},
    {8'd9,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd0}, // R9 lockout began
    {8'd9,  1'b0,1'b1,1'b0,1'b0,16'h0000,32'd0},
    {8'd9,  1'b1,1'b0,1'b0,1'b0,16'h0000,32'd0},
    {8'd9,  1'b0,1'b0,1'b0,1'b0,16'h0000,32'd1}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: count=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n = 1'b0; pin_sync = lvl; unit_tick = 1'b0; cfg_wr = 1'b0; upd_wr = 1'b0; wr_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    check(1, count, 32'd0); // R1
    for (int i = 0; i < NV; i++) begin
      {pin_sync, unit_tick, cfg_wr, upd_wr, wr_data} = VECS[i][51:32];
      @(negedge clk);
      check(int'(VECS[i][59:52]), count, VECS[i][31:0]);
    end
    unit_tick = 1'b0; cfg_wr = 1'b0;
    // R7: same-cycle read still sees old value
    upd_wr = 1'b1; wr_data = '0;
    #1 check(7, count, 32'd1);
    @(negedge clk);
    upd_wr = 1'b0;
    check(7, count, 32'd0);

    // R11: low input right after reset is no edge
    do_reset(1'b0);
    @(negedge clk);
    check(11, count, 32'd0);
    pin_sync = 1'b1;
    @(negedge clk);
    pin_sync = 1'b0;
    @(negedge clk);
    check(11, count, 32'd1); // R1 default polarity falling

    // R10: 4-bit instance wraps after 16 edges
    do_reset(1'b1);
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      pin_sync = 1'b0;
      @(negedge clk);
      pin_sync = 1'b1; unit_tick = 1'b1;
      @(negedge clk);
      unit_tick = 1'b0;
      @(negedge clk);
    end
    check(10, {28'd0, count_small}, 32'd0);
    check(10, count, 32'd16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule